// File: doc/BRIEF.md
# Context-Sensitive Memory Block Mapper

This block extends a 16-bit word-addressed processor to a physical memory of up to 64 blocks of 32K words each. On every memory cycle it splits the logical address: the low 15 bits pass through unchanged as the offset inside a block, and a 6-bit block number is placed above them. The block number is not held in one bank register. One of six mapping registers supplies it, and the choice depends on the kind of access in progress and on logical address bit 15.

There are four kinds of access, listed here from highest to lowest precedence: a bus-grant (DMA) transfer, a base-page reference, an instruction fetch, and any other data access. Every access in the last group, indirect or direct, uses the indirect-access registers. Base-page and bus-grant accesses each have one register for the whole address space. Fetches and data accesses each have one register for the lower half and one for the upper half.

The six mapping registers sit at word addresses octal 032 to 037. Software reads and writes them with ordinary cycles on the same interface. Every logical address below octal 040 is a register address. Such a cycle is flagged as a register access and produces no physical memory address. All results appear one clock after the cycle starts.

Top module: `memBlockMapper`

## Requirements
- R1: After reset all six mapping registers hold block 0, and `physValid`, `regHit` and `rdValid` are low.
- R2: A cycle started with `cycStart` high at a logical address of octal 040 or above raises `physValid` in the next clock. In that clock `physAddr[14:0]` equals the logical address bits 14..0, and `physAddr[20:15]` is the selected block. A clock with `cycStart` low gives no valid output in the next clock.
- R3: A data access (no kind input high) uses the register at octal 032 when logical bit 15 is 1, and the register at octal 035 when bit 15 is 0.
- R4: An instruction fetch (`kindFetch`) uses the register at octal 033 when bit 15 is 0, and the register at octal 034 when bit 15 is 1.
- R5: A base-page access (`kindBase`) uses the register at octal 036 in both address halves.
- R6: A bus-grant access (`kindGrant`) uses the register at octal 037 in both address halves.
- R7: When several kind inputs are high, the order of precedence is `kindGrant`, then `kindBase`, then `kindFetch`.
- R8: A cycle at logical address octal 000 to 037 raises `regHit` and keeps `physValid` low in the next clock, whatever the kind inputs are.
- R9: A write (`wrReq` high) to octal 032..037 stores `wrData[5:0]` into that mapping register, and the upper data bits are discarded. The next cycle already maps with the new value. A write to any other address, register or memory, leaves all six mapping registers unchanged.
- R10: A read of octal 032..037 raises `rdValid` in the next clock, with `rdData` equal to the stored block number zero-extended to 16 bits. A read of any other register address leaves `rdValid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cycStart | input | 1 | A cycle is presented this clock |
| logAddr | input | 16 | Logical word address |
| kindGrant | input | 1 | Access is a bus-grant (DMA) transfer |
| kindBase | input | 1 | Access is a base-page reference |
| kindFetch | input | 1 | Access is an instruction fetch |
| wrReq | input | 1 | Cycle writes (1) or reads (0) |
| wrData | input | 16 | Write data for a register cycle |
| physValid | output | 1 | physAddr holds a memory address |
| physAddr | output | 21 | Block number above 15-bit offset |
| regHit | output | 1 | Previous cycle addressed the register space |
| rdValid | output | 1 | rdData holds a mapping register value |
| rdData | output | 16 | Zero-extended block number |

## Verification
The bench loads six distinct block numbers so that a wrong register choice cannot go unnoticed. A swapped half-select would map fetches or data accesses into the other half's block. An inverted precedence would let a fetch or a base-page flag override a bus grant. The bench then writes a register and uses it in the very next cycle, which exposes a design that applies writes one cycle late. It also writes data with the upper bits set, and writes to octal 031, octal 000 and a memory address, then reads all six registers back. This catches a design that keeps stray bits or decodes the register window too widely. Address octal 037 against 040 and the values 077777 against 100000 sit on the register-space edge and the half boundary, where an off-by-one compare would flag the wrong cycle or pick the wrong half.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  // Index of each mapping register inside the file (index = word address - octal 032)
  localparam int IDX_IND_HI   = 0;  // octal 032
  localparam int IDX_FET_LO   = 1;  // octal 033
  localparam int IDX_FET_HI   = 2;  // octal 034
  localparam int IDX_IND_LO   = 3;  // octal 035
  localparam int IDX_BASE     = 4;  // octal 036
  localparam int IDX_GRANT    = 5;  // octal 037
  localparam int NUM_MAP      = 6;
  localparam int IDX_W        = $clog2(NUM_MAP);

  typedef enum logic [1:0] {
    KIND_DATA  = 2'd0,
    KIND_FETCH = 2'd1,
    KIND_BASE  = 2'd2,
    KIND_GRANT = 2'd3
  } accKind_e;

  typedef struct packed {
    logic             memStb;   // memory cycle: register the physical address
    logic             regStb;   // register-space cycle
    logic             wrStb;    // write one mapping register
    logic             rdStb;    // read one mapping register
    logic [IDX_W-1:0] regIdx;   // register addressed by a register cycle
    logic [IDX_W-1:0] selIdx;   // register chosen for address translation
  } ctrlStb_t;
endpackage

// File: rtl/mapCtrl.sv
module mapCtrl
  import mapper_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int REG_SPAN = 32,
  parameter int MAP_BASE = 26
) (
  input  logic              cycStart,
  input  logic [ADDR_W-1:0] logAddr,
  input  logic              kindGrant,
  input  logic              kindBase,
  input  logic              kindFetch,
  input  logic              wrReq,
  output ctrlStb_t          stb
);
  localparam logic [ADDR_W-1:0] SPAN_A  = ADDR_W'(REG_SPAN);
  localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(MAP_BASE);
  localparam logic [ADDR_W-1:0] LIMIT_A = ADDR_W'(MAP_BASE + NUM_MAP);

  accKind_e kind;
  logic     upperHalf;
  logic     inRegSpace;
  logic     inMapWindow;

  assign upperHalf   = logAddr[ADDR_W-1];
  assign inRegSpace  = logAddr < SPAN_A;
  assign inMapWindow = (logAddr >= BASE_A) && (logAddr < LIMIT_A);

  // Precedence: grant, base page, fetch, data
  always_comb begin
    if (kindGrant)      kind = KIND_GRANT;
    else if (kindBase)  kind = KIND_BASE;
    else if (kindFetch) kind = KIND_FETCH;
    else                kind = KIND_DATA;
  end

  always_comb begin
    stb        = '0;
    stb.memStb = cycStart && !inRegSpace;
    stb.regStb = cycStart && inRegSpace;
    stb.wrStb  = cycStart && inMapWindow && wrReq;
    stb.rdStb  = cycStart && inMapWindow && !wrReq;
    stb.regIdx = IDX_W'(logAddr - BASE_A);
    unique case (kind)
      KIND_GRANT: stb.selIdx = IDX_W'(IDX_GRANT);
      KIND_BASE:  stb.selIdx = IDX_W'(IDX_BASE);
      KIND_FETCH: stb.selIdx = upperHalf ? IDX_W'(IDX_FET_HI) : IDX_W'(IDX_FET_LO);
      default:    stb.selIdx = upperHalf ? IDX_W'(IDX_IND_HI) : IDX_W'(IDX_IND_LO);
    endcase
  end
endmodule

// File: rtl/mapDatapath.sv
module mapDatapath
  import mapper_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int BLK_W  = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStb_t                stb,
  input  logic [ADDR_W-1:0]       logAddr,
  input  logic [DATA_W-1:0]       wrData,
  output logic                    physValid,
  output logic [BLK_W+ADDR_W-2:0] physAddr,
  output logic                    regHit,
  output logic                    rdValid,
  output logic [DATA_W-1:0]       rdData
);
  localparam int OFF_W  = ADDR_W - 1;
  localparam int PHYS_W = BLK_W + OFF_W;

  logic [BLK_W-1:0] mapReg [NUM_MAP];
  logic [BLK_W-1:0] selBlk;
  logic [BLK_W-1:0] rdBlk;

  for (genvar i = 0; i < NUM_MAP; i++) begin : g_map
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        mapReg[i] <= '0;
      else if (stb.wrStb && (stb.regIdx == IDX_W'(i)))
        mapReg[i] <= wrData[BLK_W-1:0];
    end
  end

  always_comb begin
    selBlk = '0;
    rdBlk  = '0;
    for (int i = 0; i < NUM_MAP; i++) begin
      if (stb.selIdx == IDX_W'(i)) selBlk = mapReg[i];
      if (stb.regIdx == IDX_W'(i)) rdBlk  = mapReg[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      physValid <= 1'b0;
      physAddr  <= '0;
      regHit    <= 1'b0;
      rdValid   <= 1'b0;
      rdData    <= '0;
    end else begin
      physValid <= stb.memStb;
      regHit    <= stb.regStb;
      rdValid   <= stb.rdStb;
      if (stb.memStb) physAddr <= PHYS_W'({selBlk, logAddr[OFF_W-1:0]});
      if (stb.rdStb)  rdData   <= DATA_W'(rdBlk);
    end
  end
endmodule

// File: rtl/memBlockMapper.sv
module memBlockMapper
  import mapper_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int BLK_W    = 6,
  parameter int REG_SPAN = 32,
  parameter int MAP_BASE = 26
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cycStart,
  input  logic [ADDR_W-1:0]       logAddr,
  input  logic                    kindGrant,
  input  logic                    kindBase,
  input  logic                    kindFetch,
  input  logic                    wrReq,
  input  logic [DATA_W-1:0]       wrData,
  output logic                    physValid,
  output logic [BLK_W+ADDR_W-2:0] physAddr,
  output logic                    regHit,
  output logic                    rdValid,
  output logic [DATA_W-1:0]       rdData
);
  ctrlStb_t stb;

  mapCtrl #(.ADDR_W(ADDR_W), .REG_SPAN(REG_SPAN), .MAP_BASE(MAP_BASE)) u_ctrl (
    .cycStart (cycStart),
    .logAddr  (logAddr),
    .kindGrant(kindGrant),
    .kindBase (kindBase),
    .kindFetch(kindFetch),
    .wrReq    (wrReq),
    .stb      (stb)
  );

  mapDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .logAddr  (logAddr),
    .wrData   (wrData),
    .physValid(physValid),
    .physAddr (physAddr),
    .regHit   (regHit),
    .rdValid  (rdValid),
    .rdData   (rdData)
  );
endmodule

// File: rtl/mapperChecker.sv
module mapperChecker #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int BLK_W    = 6,
  parameter int REG_SPAN = 32
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    cycStart,
  input logic [ADDR_W-1:0]       logAddr,
  input logic                    wrReq,
  input logic                    physValid,
  input logic [BLK_W+ADDR_W-2:0] physAddr,
  input logic                    regHit,
  input logic                    rdValid,
  input logic [DATA_W-1:0]       rdData
);
  localparam int OFF_W = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(REG_SPAN);

  AST_MEM_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (cycStart && logAddr >= SPAN_A) |=> physValid);  // R2
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (cycStart && logAddr >= SPAN_A) |=> physAddr[OFF_W-1:0] == $past(logAddr[OFF_W-1:0]));  // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !cycStart |=> (!physValid && !regHit && !rdValid));  // R2
  AST_REG_SPACE: assert property (@(posedge clk) disable iff (!rstN)
    (cycStart && logAddr < SPAN_A) |=> (regHit && !physValid));  // R8
  AST_WRITE_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (cycStart && wrReq) |=> !rdValid);  // R9
  AST_READ_ZEXT: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdData[DATA_W-1:BLK_W] == '0));  // R10
endmodule

bind memBlockMapper mapperChecker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W), .REG_SPAN(REG_SPAN)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cycStart (cycStart),
  .logAddr  (logAddr),
  .wrReq    (wrReq),
  .physValid(physValid),
  .physAddr (physAddr),
  .regHit   (regHit),
  .rdValid  (rdValid),
  .rdData   (rdData)
);

// File: tb/memBlockMapper_tb.sv
module memBlockMapper_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cycStart = 1'b0;
  logic [15:0] logAddr = '0;
  logic        kindGrant = 1'b0, kindBase = 1'b0, kindFetch = 1'b0, wrReq = 1'b0;
  logic [15:0] wrData = '0;
  logic        physValid, regHit, rdValid;
  logic [20:0] physAddr;
  logic [15:0] rdData;

  int checks = 0;
  int errors = 0;
  logic [5:0] mdl [6];

  always #(CLK_PERIOD/2) clk = ~clk;

  memBlockMapper u_dut (
    .clk(clk), .rstN(rstN), .cycStart(cycStart), .logAddr(logAddr),
    .kindGrant(kindGrant), .kindBase(kindBase), .kindFetch(kindFetch),
    .wrReq(wrReq), .wrData(wrData), .physValid(physValid), .physAddr(physAddr),
    .regHit(regHit), .rdValid(rdValid), .rdData(rdData)
  );

  // Register index for a translated access: 0..5 = octal 032..037
  function automatic int expIdx(logic g, logic b, logic f, logic hi);
    if (g) return 5;
    if (b) return 4;
    if (f) return hi ? 2 : 1;
    return hi ? 0 : 3;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present one cycle at a negedge and check the outputs at the following negedge
  task automatic doCyc(string req, logic [15:0] a, logic g, logic b, logic f,
                       logic w, logic [15:0] d);
    logic isReg, isMap;
    int   ri, si;
    logic [5:0] expRd;
    isReg = a < 16'd32;
    isMap = (a >= 16'd26) && (a <= 16'd31);
    ri = int'(a) - 26;
    si = expIdx(g, b, f, a[15]);
    expRd = isMap ? mdl[ri] : 6'd0;
    cycStart = 1'b1; logAddr = a; kindGrant = g; kindBase = b; kindFetch = f;
    wrReq = w; wrData = d;
    @(negedge clk);
    cycStart = 1'b0;
    chk({req, " physValid"}, 32'(physValid), 32'(!isReg));
    chk({req, " regHit"}, 32'(regHit), 32'(isReg));
    chk({req, " rdValid"}, 32'(rdValid), 32'(isReg && isMap && !w));
    if (!isReg) chk({req, " physAddr"}, 32'(physAddr), 32'({mdl[si], a[14:0]}));
    if (isReg && isMap && !w) chk({req, " rdData"}, 32'(rdData), 32'(expRd));
    if (isMap && w) mdl[ri] = d[5:0];
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    for (int i = 0; i < 6; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk("R1 reset physValid", 32'(physValid), 0);
    chk("R1 reset rdValid", 32'(rdValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle regHit", 32'(regHit), 0);
    // R1: all registers read back as block 0
    for (int i = 26; i < 32; i++) doCyc("R1 R10 reset readback", 16'(i), 0, 0, 0, 0, 0);
    // R1: a translation right after reset lands in block 0
    doCyc("R1 R2 block0", 16'h8123, 0, 0, 0, 0, 0);
    // R9: load distinct values, upper data bits must be dropped
    for (int i = 0; i < 6; i++)
      doCyc("R9 load", 16'(26 + i), 0, 0, 0, 1, 16'hFFC0 | 16'(11 + 9*i));
    // R10: read back
    for (int i = 26; i < 32; i++) doCyc("R10 readback", 16'(i), 0, 0, 0, 0, 0);
    // R3 data halves, boundary 077777/100000
    doCyc("R3 data lo edge", 16'h7FFF, 0, 0, 0, 0, 0);
    doCyc("R3 data hi edge", 16'h8000, 0, 0, 0, 1, 16'h1234);
    // R4 fetch halves
    doCyc("R4 fetch lo", 16'h0020, 0, 0, 1, 0, 0);
    doCyc("R4 fetch hi", 16'hFFFF, 0, 0, 1, 0, 0);
    // R5 base page both halves (octal 177000 and 000777)
    doCyc("R5 base hi", 16'hFE00, 0, 1, 0, 0, 0);
    doCyc("R5 base lo", 16'h01FF, 0, 1, 0, 0, 0);
    // R6 grant both halves
    doCyc("R6 grant lo", 16'h4000, 1, 0, 0, 0, 0);
    doCyc("R6 grant hi", 16'hC000, 1, 0, 0, 1, 0);
    // R7 precedence
    doCyc("R7 grant over all", 16'h9000, 1, 1, 1, 0, 0);
    doCyc("R7 base over fetch", 16'h1000, 0, 1, 1, 0, 0);
    doCyc("R7 grant over fetch", 16'h1000, 1, 0, 1, 0, 0);
    // R8 register space edges
    doCyc("R8 edge 037", 16'd31, 1, 0, 0, 0, 0);
    doCyc("R8 edge 040", 16'd32, 0, 0, 0, 0, 0);
    doCyc("R8 addr 0", 16'd0, 0, 1, 1, 0, 0);
    // R9: ignored writes, then read back all six
    doCyc("R9 write 031", 16'd25, 0, 0, 0, 1, 16'h003F);
    doCyc("R9 write 000", 16'd0, 0, 0, 0, 1, 16'h003F);
    doCyc("R9 write mem", 16'h001A + 16'h8000, 0, 0, 0, 1, 16'h003F);
    for (int i = 26; i < 32; i++) doCyc("R9 R10 unchanged", 16'(i), 0, 0, 0, 0, 0);
    // R9: write then use in the very next cycle
    doCyc("R9 write 034", 16'd28, 0, 0, 0, 1, 16'h0029);
    doCyc("R9 R4 immediate use", 16'hA5A5, 0, 0, 1, 0, 0);
    // idle gap
    @(negedge clk);
    chk("R2 idle physValid", 32'(physValid), 0);
    // Random mix
    for (int n = 0; n < 600; n++) begin
      logic [15:0] a;
      logic [3:0]  k;
      a = 16'($urandom);
      if ($urandom_range(0, 7) == 0) a = 16'($urandom_range(0, 31));
      k = 4'($urandom);
      doCyc("R2 R7 random", a, k[0] & k[1], k[2] & k[3], k[1], 1'($urandom), 16'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule